// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block holds recently used virtual-to-physical page mappings so that a memory access can be translated without reading the page table. A requester presents a virtual page number, a page offset and the kind of access: read or write, user or supervisor. In the same cycle the block reports one of three outcomes: a hit with the physical page number, a miss, or a protection fault. The physical address is the physical page number followed by the unchanged offset.

The cache holds 16 entries in 4 sets of 4 ways. The low two bits of the 8-bit virtual page number select the set. The upper six bits are the tag, and all four ways of the selected set compare their tags at the same time. After a miss, an external table walker reads the page table entry and installs it through the refill port. That entry answers lookups from the next cycle on. A flush input marks every entry invalid on a context switch, except entries installed as global.

Top module: `tlb_xlate`

## Requirements
- R1: After reset no entry is valid, and every lookup reports a miss.
- R2: The set is VPN bits [1:0] and the tag is VPN bits [7:2]. A lookup hits only when a valid way of that set holds the same tag. It then raises `lk_hit` in the same cycle and puts the stored PPN on `lk_ppn`.
- R3: A lookup with no matching valid way raises only `lk_miss`, and `lk_ppn` and `lk_paddr` read zero. A refill is not visible to a lookup in the cycle it is presented, and it is visible from the next cycle on.
- R4: Each entry holds three permission bits: supervisor-only, readable and writable. A matching lookup raises `lk_fault` instead of `lk_hit` in any of these cases: the entry is supervisor-only and `lk_super` is 0; `lk_write` is 1 and the entry is not writable; `lk_write` is 0 and the entry is not readable. On a fault `lk_ppn` and `lk_paddr` read zero.
- R5: A refill of a VPN that is not present goes into the lowest-numbered invalid way of its set. If every way is valid, it goes into the way named by that set's round-robin pointer. The pointer starts at 0 and moves up by one, wrapping around, only on such a replacement.
- R6: A flush invalidates every entry whose global bit is 0. Global entries keep translating.
- R7: When a flush and a refill arrive in the same cycle, the refilled entry is valid afterwards, whatever its global bit.
- R8: A refill of a VPN already present overwrites the matching way, including its PPN and permissions. No set ever holds two valid ways with the same tag.
- R9: On a hit `lk_paddr` equals {PPN, `lk_off`}, with the 6-bit offset unchanged in the low bits.
- R10: While `lk_valid` is 0, `lk_hit`, `lk_miss` and `lk_fault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | 8 | Virtual page number to translate |
| lk_off | input | 6 | Page offset passed through to the physical address |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_super | input | 1 | Requester runs in supervisor mode |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No valid entry for the VPN |
| lk_fault | output | 1 | Entry found but access not permitted |
| lk_ppn | output | 6 | Physical page number on a hit, else zero |
| lk_paddr | output | 12 | Physical address on a hit, else zero |
| rf_valid | input | 1 | Install an entry this cycle |
| rf_vpn | input | 8 | VPN of the entry to install |
| rf_ppn | input | 6 | PPN of the entry to install |
| rf_super_only | input | 1 | Entry usable in supervisor mode only |
| rf_read_ok | input | 1 | Entry allows reads |
| rf_write_ok | input | 1 | Entry allows writes |
| rf_global | input | 1 | Entry survives a flush |
| flush | input | 1 | Context-switch invalidate of non-global entries |

## Verification
A wrong victim choice or a round-robin pointer that moves at the wrong time is not visible when the refill happens. It shows up later, as a miss on a VPN that should still be cached, or as a hit on one that should have been evicted. The bench therefore looks up the surviving and the evicted VPNs right after each replacement in a full set. A flush that clears too much or too little shows up on the first lookup after it. A bad permission decode shows up at once, as a hit and fault swapped on the same cycle. A duplicated tag shows up as a corrupted PPN, because the matching ways are ORed together.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VPN_W = 8;
    localparam int IDX_W = 2;
    localparam int PPN_W = 6;
    localparam int OFF_W = 6;
    localparam int WAYS  = 4;
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int SETS  = 1 << IDX_W;
    localparam int WAY_W = $clog2(WAYS);
    localparam int PA_W  = PPN_W + OFF_W;

    typedef struct packed {
        logic             vld;
        logic             glob;
        logic             sup;
        logic             rd;
        logic             wr;
        logic [TAG_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
    } tlb_entry_t;

    typedef struct packed {
        tlb_entry_t [SETS-1:0][WAYS-1:0] ent;
        logic       [SETS-1:0][WAY_W-1:0] rr;
    } tlb_state_t;
endpackage

// File: rtl/tlb_set_match.sv
module tlb_set_match
    import tlb_pkg::*;
(
    input  tlb_entry_t [WAYS-1:0] ents,
    input  logic [TAG_W-1:0]      tag,
    output logic [WAYS-1:0]       hit,
    output tlb_entry_t            sel
);
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hit[g] = ents[g].vld && (ents[g].tag == tag);
    end

    always_comb begin
        sel = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hit[i]) sel = tlb_entry_t'(sel | ents[i]);
        end
    end
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] vld,
    input  logic [N-1:0] hit,
    input  logic [W-1:0] rr,
    output logic [W-1:0] way,
    output logic         use_rr
);
    always_comb begin
        way    = rr;
        use_rr = 1'b1;
        if (|hit) begin
            use_rr = 1'b0;
            for (int i = 0; i < N; i++) begin
                if (hit[i]) way = W'(i);
            end
        end else begin
            for (int i = N - 1; i >= 0; i--) begin
                if (!vld[i]) begin
                    way    = W'(i);
                    use_rr = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [OFF_W-1:0] lk_off,
    input  logic             lk_write,
    input  logic             lk_super,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic [PPN_W-1:0] lk_ppn,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             rf_valid,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [PPN_W-1:0] rf_ppn,
    input  logic             rf_super_only,
    input  logic             rf_read_ok,
    input  logic             rf_write_ok,
    input  logic             rf_global,
    input  logic             flush
);
    tlb_state_t q, d;

    // Lookup path
    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [WAYS-1:0]  lk_match;
    tlb_entry_t       lk_sel;
    logic             lk_any, lk_viol;

    assign lk_idx = lk_vpn[IDX_W-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:IDX_W];

    tlb_set_match u_look (
        .ents (q.ent[lk_idx]),
        .tag  (lk_tag),
        .hit  (lk_match),
        .sel  (lk_sel)
    );

    always_comb begin
        lk_any   = |lk_match;
        lk_viol  = (lk_sel.sup && !lk_super) || (lk_write ? !lk_sel.wr : !lk_sel.rd);
        lk_hit   = lk_valid && lk_any && !lk_viol;
        lk_fault = lk_valid && lk_any && lk_viol;
        lk_miss  = lk_valid && !lk_any;
        lk_ppn   = lk_hit ? lk_sel.ppn : '0;
        lk_paddr = lk_hit ? {lk_sel.ppn, lk_off} : '0;
    end

    // Refill path
    logic [IDX_W-1:0] rf_idx;
    logic [TAG_W-1:0] rf_tag;
    logic [WAYS-1:0]  rf_match, rf_vld;
    tlb_entry_t       rf_sel_unused;
    logic [WAY_W-1:0] rf_way;
    logic             rf_use_rr;

    assign rf_idx = rf_vpn[IDX_W-1:0];
    assign rf_tag = rf_vpn[VPN_W-1:IDX_W];

    tlb_set_match u_rmatch (
        .ents (q.ent[rf_idx]),
        .tag  (rf_tag),
        .hit  (rf_match),
        .sel  (rf_sel_unused)
    );

    for (genvar g = 0; g < WAYS; g++) begin : g_vld
        assign rf_vld[g] = q.ent[rf_idx][g].vld;
    end

    tlb_victim_pick #(.N(WAYS), .W(WAY_W)) u_vict (
        .vld    (rf_vld),
        .hit    (rf_match),
        .rr     (q.rr[rf_idx]),
        .way    (rf_way),
        .use_rr (rf_use_rr)
    );

    always_comb begin
        d = q;
        if (flush) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (!q.ent[s][w].glob) d.ent[s][w].vld = 1'b0;
                end
            end
        end
        if (rf_valid) begin
            d.ent[rf_idx][rf_way] = '{vld: 1'b1, glob: rf_global, sup: rf_super_only,
                                     rd: rf_read_ok, wr: rf_write_ok,
                                     tag: rf_tag, ppn: rf_ppn};
            if (rf_use_rr) d.rr[rf_idx] = q.rr[rf_idx] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Assertion helpers
    function automatic int count_live(input tlb_state_t s, input bit only_local);
        int n = 0;
        for (int i = 0; i < SETS; i++)
            for (int w = 0; w < WAYS; w++)
                if (s.ent[i][w].vld && !(only_local && s.ent[i][w].glob)) n++;
        return n;
    endfunction

    function automatic bit vpn_resident(input tlb_state_t s, input logic [VPN_W-1:0] v);
        bit r = 1'b0;
        for (int w = 0; w < WAYS; w++)
            if (s.ent[v[IDX_W-1:0]][w].vld && s.ent[v[IDX_W-1:0]][w].tag == v[VPN_W-1:IDX_W])
                r = 1'b1;
        return r;
    endfunction

    a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> count_live(q, 1'b0) == 0);
    a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
    a_r3_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (!lk_hit && !lk_fault && lk_ppn == '0 && lk_paddr == '0));
    a_r3_refill_resident: assert property (@(posedge clk) disable iff (!rst_n)
        rf_valid |=> vpn_resident(q, $past(rf_vpn)));
    a_r6_flush_spares_global: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !rf_valid) |=> count_live(q, 1'b1) == 0);
    a_r9_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[OFF_W-1:0] == lk_off);
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault));
endmodule

// File: tb/tlb_xlate_tb.sv
module tlb_xlate_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lk_valid = 0, lk_write = 0, lk_super = 0;
    logic [7:0] lk_vpn = 0;
    logic [5:0] lk_off = 0;
    logic lk_hit, lk_miss, lk_fault;
    logic [5:0] lk_ppn;
    logic [11:0] lk_paddr;
    logic rf_valid = 0, rf_super_only = 0, rf_read_ok = 0, rf_write_ok = 0, rf_global = 0, flush = 0;
    logic [7:0] rf_vpn = 0;
    logic [5:0] rf_ppn = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_xlate u_dut (.*);

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Reference model
    bit       m_vld [4][4], m_glob [4][4], m_sup [4][4], m_rd [4][4], m_wr [4][4];
    bit [5:0] m_tag [4][4], m_ppn [4][4];
    int       m_rr  [4];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic predict(input bit [7:0] vpn, input bit [5:0] off, input bit wr, input bit sup,
                           output bit [20:0] e);
        int s = vpn[1:0];
        bit h = 0, m = 1, f = 0;
        bit [5:0] p = 0;
        for (int w = 0; w < 4; w++) begin
            if (m_vld[s][w] && m_tag[s][w] == vpn[7:2]) begin
                m = 0;
                if ((m_sup[s][w] && !sup) || (wr ? !m_wr[s][w] : !m_rd[s][w])) f = 1;
                else begin h = 1; p = m_ppn[s][w]; end
            end
        end
        e = {h, m, f, p, (h ? {p, off} : 12'h0)};
    endtask

    task automatic model_step(input bit rv, input bit [7:0] v, input bit [5:0] p,
                              input bit su, input bit rd, input bit wr, input bit gl, input bit fl);
        int s = v[1:0];
        int way = -1;
        if (rv) begin
            for (int w = 0; w < 4; w++) if (m_vld[s][w] && m_tag[s][w] == v[7:2]) way = w;
            if (way < 0) for (int w = 3; w >= 0; w--) if (!m_vld[s][w]) way = w;
            if (way < 0) begin way = m_rr[s]; m_rr[s] = (m_rr[s] + 1) % 4; end
        end
        if (fl) for (int i = 0; i < 4; i++) for (int w = 0; w < 4; w++) if (!m_glob[i][w]) m_vld[i][w] = 0;
        if (rv) begin
            m_vld[s][way] = 1; m_glob[s][way] = gl; m_sup[s][way] = su;
            m_rd[s][way] = rd; m_wr[s][way] = wr; m_tag[s][way] = v[7:2]; m_ppn[s][way] = p;
        end
    endtask

    // One cycle: drive at negedge, check combinational result, update model for the coming edge
    task automatic cyc(input bit lv, input bit [7:0] v, input bit [5:0] off, input bit wr, input bit sup,
                       input bit rv, input bit [7:0] rvv, input bit [5:0] rp,
                       input bit rsu, input bit rrd, input bit rwr, input bit rgl,
                       input bit fl, input string req);
        bit [20:0] e;
        @(negedge clk);
        lk_valid = lv; lk_vpn = v; lk_off = off; lk_write = wr; lk_super = sup;
        rf_valid = rv; rf_vpn = rvv; rf_ppn = rp; rf_super_only = rsu;
        rf_read_ok = rrd; rf_write_ok = rwr; rf_global = rgl; flush = fl;
        #1;
        if (lv) begin
            predict(v, off, wr, sup, e);
            chk({lk_hit, lk_miss, lk_fault, lk_ppn, lk_paddr} == e, req,
                int'({lk_hit, lk_miss, lk_fault, lk_ppn, lk_paddr}), int'(e));
        end else begin
            chk({lk_hit, lk_miss, lk_fault} == 3'b000, req, int'({lk_hit, lk_miss, lk_fault}), 0);
        end
        model_step(rv, rvv, rp, rsu, rrd, rwr, rgl, fl);
    endtask

    task automatic look(input bit [7:0] v, input bit wr, input bit sup, input string req);
        cyc(1, v, 6'h2b, wr, sup, 0, 0, 0, 0, 0, 0, 0, 0, req);
    endtask

    task automatic fill(input bit [7:0] v, input bit [5:0] p, input bit su, input bit rd,
                        input bit wr, input bit gl, input string req);
        cyc(0, 0, 0, 0, 0, 1, v, p, su, rd, wr, gl, 0, req);
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        report();
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_rr[i] = 0;
            for (int w = 0; w < 4; w++) begin
                m_vld[i][w] = 0; m_glob[i][w] = 0; m_sup[i][w] = 0;
                m_rd[i][w] = 0; m_wr[i][w] = 0; m_tag[i][w] = 0; m_ppn[i][w] = 0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        look(8'h00, 0, 1, "R1 reset miss");
        look(8'hfd, 0, 1, "R1 reset miss");
        // R10: idle request
        cyc(0, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 idle");
        // R2/R9: fill set 1 with tags 1..4
        for (int t = 1; t <= 4; t++) fill({6'(t), 2'b01}, 6'(t + 10), 0, 1, 1, 0, "R5 fill");
        for (int t = 1; t <= 4; t++) look({6'(t), 2'b01}, 0, 0, "R2 R9 hit");
        look({6'd1, 2'b10}, 0, 0, "R2 other set miss");
        // R3: refill visible only from next cycle
        cyc(1, 8'h80, 6'h11, 0, 0, 1, 8'h80, 6'h3f, 0, 1, 1, 0, 0, "R3 same-cycle miss");
        look(8'h80, 0, 0, "R3 visible next cycle");
        // R5: round-robin eviction in full set
        fill({6'd5, 2'b01}, 6'd15, 0, 1, 1, 0, "R5 evict");
        look({6'd1, 2'b01}, 0, 0, "R5 evicted way0");
        look({6'd5, 2'b01}, 0, 0, "R5 new hit");
        fill({6'd6, 2'b01}, 6'd16, 0, 1, 1, 0, "R5 evict");
        look({6'd2, 2'b01}, 0, 0, "R5 evicted way1");
        // R8: overwrite resident VPN
        fill({6'd4, 2'b01}, 6'h2a, 0, 1, 1, 0, "R8 overwrite");
        look({6'd4, 2'b01}, 0, 0, "R8 new ppn");
        for (int t = 3; t <= 6; t++) look({6'(t), 2'b01}, 0, 0, "R8 others kept");
        // R4: permissions
        fill(8'h02, 6'h05, 1, 1, 0, 0, "R4 fill");
        look(8'h02, 0, 0, "R4 user on supervisor page");
        look(8'h02, 0, 1, "R4 supervisor read");
        look(8'h02, 1, 1, "R4 write to read-only");
        fill(8'h06, 6'h07, 0, 0, 1, 0, "R4 fill");
        look(8'h06, 0, 0, "R4 read of write-only");
        look(8'h06, 1, 0, "R4 write ok");
        // R6: flush spares global
        fill(8'h03, 6'h09, 0, 1, 1, 1, "R6 fill global");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R6 flush");
        look(8'h03, 0, 0, "R6 global survives");
        look(8'h02, 0, 1, "R6 local flushed");
        look({6'd5, 2'b01}, 0, 0, "R6 local flushed");
        // R7: flush and refill together
        cyc(0, 0, 0, 0, 0, 1, 8'h44, 6'h21, 0, 1, 1, 0, 1, "R7 flush+fill");
        look(8'h44, 0, 0, "R7 refilled survives");

        // Random phase
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 5000; i++) begin
            bit [7:0] v  = {3'b0, 3'($urandom), 2'($urandom)};
            bit [7:0] rv = {3'b0, 3'($urandom), 2'($urandom)};
            cyc(($urandom % 8) != 0, v, 6'($urandom), 1'($urandom), 1'($urandom),
                ($urandom % 3) == 0, rv, 6'($urandom),
                ($urandom % 4) == 0, ($urandom % 8) != 0, ($urandom % 4) != 0, ($urandom % 8) == 0,
                ($urandom % 97) == 0, "R2 R4 R5 R6 R8 random");
        end
        report();
    end
endmodule